// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave serial port that gives a host access to a small bank of 8-bit configuration registers. The host supplies a serial clock, a serial data line and an enable strobe. The block drives one serial data output. Each frame carries a 6-bit address and then a data byte, both most significant bit first. A rising edge of the strobe commits the frame.

Address bit 4 selects the operation. When the bit is clear, the frame writes the data byte into the addressed register, or it resets the whole bank when the address is the reserved command address 000100. When the bit is set, the data byte is ignored and the register at the address with bit 4 cleared is shifted out on the serial output, one bit per falling edge of the serial clock. The next frame can be shifted in while that byte is still being sent. The register contents are also presented in parallel to the rest of the chip.

All inputs are sampled by the system clock `clk`, and the serial clock edges are detected from those samples. The serial clock must stay in each level for at least two system clock cycles.

Top module: `scp_ctrl_port`

## Requirements
- R1: On each rising edge of `sck`, one bit is taken from `sdi`. A frame is the last 14 bits taken: address [13:8] first, then data [7:0], MSB first. A rising edge of `sen` commits the frame, and its effect is visible on `reg_q` no later than two `clk` cycles after `sen` is seen high.
- R2: A write frame (address bit 4 = 0) to an implemented register (address below NUM_REGS = 8, other than 000100) loads the data byte into byte `address` of `reg_q`. It leaves every other byte unchanged.
- R3: A write frame to an address at or above NUM_REGS changes no register.
- R4: A write frame to address 000100, with any data byte, returns every register to its default value. The defaults, as `reg_q`, are 64'h8877_6600_4433_2211.
- R5: A read frame (address bit 4 = 1) changes no register. Its data byte is ignored. After the strobe, the register at the address with bit 4 cleared appears on `sdo`: bit 7 after the first falling edge of `sck`, and one further bit after each later falling edge, down to bit 0.
- R6: `sdo` is low when no read-back is in progress. It is low between the read strobe and the first falling edge. It returns low on the ninth falling edge after a read strobe.
- R7: A read of an address that does not select an implemented register returns 0x00. This includes 010100 (the reserved address) and any address whose bit 5 is set.
- R8: A strobe that follows fewer than 14 `sck` rising edges since the previous strobe is ignored. When more than 14 bits arrive, only the last 14 form the frame.
- R9: A frame can be shifted in while a read-back is being sent. Both the read-back bits and the new frame's effect are correct.
- R10: While `rst` is high, all registers load their defaults, `sdo` is low and the partial frame is discarded. Byte 4 of `reg_q` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| sen | input | 1 | Frame commit strobe |
| sdo | output | 1 | Serial read-back data |
| reg_q | output | NUM_REGS*8 | Parallel register contents, byte i = register i |

## Verification
The assertions check two rules on every cycle:
- `reg_q` only moves in the cycle after a strobe edge, and `sdo` only moves after a serial clock falling edge or a strobe.
- `sdo` is never high more than eight falling edges after a strobe, and the reset state holds as reset releases.

The values written, the bit order of the read-back, the decoding of the reserved address and the invalid addresses, the frame-length rule and the overlap of a read-back with the next frame can only be shown by the bench's scenarios. The bench computes the expected register image independently.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int OP_BIT  = 4;
    localparam logic [ADDR_W-1:0] SRST_ADDR = 6'b000100;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        CMD_WRITE,
        CMD_READ,
        CMD_SRST
    } cmd_e;

    function automatic cmd_e frame_cmd(input frame_t f);
        if (f.addr[OP_BIT])          return CMD_READ;
        else if (f.addr == SRST_ADDR) return CMD_SRST;
        else                          return CMD_WRITE;
    endfunction

    function automatic logic [ADDR_W-1:0] target_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = a;
        t[OP_BIT] = 1'b0;
        return t;
    endfunction

endpackage

// File: rtl/scp_frame_rx.sv
module scp_frame_rx
    import scp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck,
    input  logic   sdi,
    input  logic   sen,
    output frame_t frame,
    output logic   commit,
    output logic   sck_fall
);

    logic               sck_d;
    logic               sen_d;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   nbits;
    logic               sck_rise;
    logic               sen_rise;

    assign sck_rise = sck & ~sck_d;
    assign sck_fall = ~sck & sck_d;
    assign sen_rise = sen & ~sen_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            sen_d <= 1'b0;
            shreg <= '0;
            nbits <= '0;
        end else begin
            sck_d <= sck;
            sen_d <= sen;
            if (sen_rise) begin
                nbits <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[FRAME_W-2:0], sdi};
                if (nbits != CNT_W'(FRAME_W))
                    nbits <= nbits + 1'b1;
            end
        end
    end

    assign frame  = frame_t'(shreg);
    assign commit = sen_rise && (nbits == CNT_W'(FRAME_W));

endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
    import scp_pkg::*;
#(
    parameter int                     NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0]  DEFAULTS = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    srst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NUM_REGS*8-1:0]   store
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == int'(SRST_ADDR)) begin : g_hole
            assign store[i*DATA_W +: DATA_W] = '0;
        end else begin : g_cell
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst || srst)
                    r <= DEFAULTS[i*DATA_W +: DATA_W];
                else if (wr_en && wr_addr == ADDR_W'(i))
                    r <= wr_data;
            end
            assign store[i*DATA_W +: DATA_W] = r;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = store[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/scp_readout.sv
module scp_readout
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_fall,
    output logic              sdo
);

    localparam int LEFT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] out_sh;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sh <= '0;
            left   <= '0;
            sdo    <= 1'b0;
        end else if (load) begin
            out_sh <= load_data;
            left   <= LEFT_W'(DATA_W);
            sdo    <= 1'b0;
        end else if (sck_fall) begin
            if (left != '0) begin
                sdo    <= out_sh[DATA_W-1];
                out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                left   <= left - 1'b1;
            end else begin
                sdo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
    import scp_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'h8877_6655_4433_2211
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck,
    input  logic                  sdi,
    input  logic                  sen,
    output logic                  sdo,
    output logic [NUM_REGS*8-1:0] reg_q
);

    frame_t            frame;
    logic              commit;
    logic              sck_fall;
    cmd_e              cmd;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    scp_frame_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .sdi      (sdi),
        .sen      (sen),
        .frame    (frame),
        .commit   (commit),
        .sck_fall (sck_fall)
    );

    assign cmd     = frame_cmd(frame);
    assign rd_addr = target_addr(frame.addr);

    scp_regbank #(
        .NUM_REGS (NUM_REGS),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .srst    (commit && cmd == CMD_SRST),
        .wr_en   (commit && cmd == CMD_WRITE),
        .wr_addr (frame.addr),
        .wr_data (frame.data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .store   (reg_q)
    );

    scp_readout u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (commit && cmd == CMD_READ),
        .load_data (rd_data),
        .sck_fall  (sck_fall),
        .sdo       (sdo)
    );

endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk
    import scp_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sck,
    input logic                  sen,
    input logic                  sdo,
    input logic [NUM_REGS*8-1:0] reg_q
);

    function automatic logic [NUM_REGS*8-1:0] masked_defaults();
        logic [NUM_REGS*8-1:0] m;
        m = DEFAULTS;
        if (int'(SRST_ADDR) < NUM_REGS)
            m[int'(SRST_ADDR)*8 +: 8] = '0;
        return m;
    endfunction

    localparam logic [NUM_REGS*8-1:0] RESET_IMG = masked_defaults();

    logic       sck_q;
    logic       sen_q;
    logic [3:0] falls;
    logic       fall_ev;
    logic       strobe_ev;

    assign fall_ev   = sck_q & ~sck;
    assign strobe_ev = sen & ~sen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sen_q <= 1'b0;
            falls <= '0;
        end else begin
            sck_q <= sck;
            sen_q <= sen;
            if (strobe_ev)
                falls <= '0;
            else if (fall_ev && falls != 4'hF)
                falls <= falls + 1'b1;
        end
    end

    // Registers move only after a strobe edge.
    assert_reg_on_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_q) |-> $past(strobe_ev));

    // The serial output moves only on a falling edge or a strobe.
    assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(fall_ev || strobe_ev));

    // At most eight bits follow a strobe.
    assert_sdo_window_R6: assert property (@(posedge clk) disable iff (rst)
        sdo |-> (falls <= 4'd8));

    // Reset state as reset releases.
    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sdo && reg_q == RESET_IMG));

endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(
    .NUM_REGS (NUM_REGS),
    .DEFAULTS (DEFAULTS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sck   (sck),
    .sen   (sen),
    .sdo   (sdo),
    .reg_q (reg_q)
);

// File: tb/scp_ctrl_port_tb.sv
module scp_ctrl_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] RESET_IMG = 64'h8877_6600_4433_2211;

    typedef struct packed {
        logic [5:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{6'h00, 8'hA5, 8'hA5},
        '{6'h07, 8'h3C, 8'h3C},
        '{6'h03, 8'h00, 8'h00},
        '{6'h08, 8'hFF, 8'h00},
        '{6'h22, 8'h5A, 8'h00},
        '{6'h05, 8'hC9, 8'hC9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sen = 1'b0;
    logic        sdo;
    logic [63:0] reg_q;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [63:0] img;
    logic [13:0] seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_ctrl_port u_dut (
        .clk   (clk),
        .rst   (rst),
        .sck   (sck),
        .sdi   (sdi),
        .sen   (sen),
        .sdo   (sdo),
        .reg_q (reg_q)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input int n, input logic [31:0] bits, output logic [13:0] got);
        got = '0;
        for (int k = n - 1; k >= 0; k--) begin
            sdi = bits[k];
            waitn(2);
            sck = 1'b1;
            waitn(2);
            sck = 1'b0;
            waitn(2);
            if (k < 14) got[k] = sdo;
        end
    endtask

    task automatic strobe();
        sen = 1'b1;
        waitn(2);
        sen = 1'b0;
        waitn(2);
    endtask

    task automatic frame(input logic [5:0] a, input logic [7:0] d, output logic [13:0] got);
        shift_bits(14, {18'h0, a, d}, got);
        strobe();
    endtask

    function automatic bit is_reg(input logic [5:0] a);
        return (a < 6'd8) && (a != 6'd4);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        waitn(4);
        rst = 1'b0;
        waitn(2);
        img = RESET_IMG;
        chk(reg_q == RESET_IMG, "R10 reset image", reg_q, RESET_IMG);
        chk(sdo == 1'b0, "R10 sdo after reset", {63'h0, sdo}, 64'h0);

        // table: write, check image; read, clock out, check bits
        foreach (VECS[i]) begin
            frame(VECS[i].a, VECS[i].d, seen);
            if (is_reg(VECS[i].a)) img[VECS[i].a*8 +: 8] = VECS[i].d;
            chk(reg_q == img, "R2 R3 write image", reg_q, img);
            frame(VECS[i].a | 6'h10, 8'hC3, seen);
            chk(reg_q == img, "R5 read leaves registers", reg_q, img);
            chk(sdo == 1'b0, "R6 low before first fall", {63'h0, sdo}, 64'h0);
            frame(6'h30, 8'h00, seen);
            chk(seen[13:6] == VECS[i].e, "R5 R7 readback byte", {56'h0, seen[13:6]}, {56'h0, VECS[i].e});
            chk(seen[5:0] == 6'h0, "R6 idle after eighth bit", {58'h0, seen[5:0]}, 64'h0);
        end

        // R8: short frame ignored
        shift_bits(10, {22'h0, 10'b0000011111}, seen);
        strobe();
        chk(reg_q == img, "R8 short frame ignored", reg_q, img);

        // R8: long frame, last 14 bits count
        shift_bits(18, {14'h0, 4'b1011, 6'h02, 8'h7E}, seen);
        strobe();
        img[2*8 +: 8] = 8'h7E;
        chk(reg_q == img, "R8 long frame last 14 bits", reg_q, img);

        // R7: reserved address read returns zero
        frame(6'h14, 8'hFF, seen);
        frame(6'h30, 8'h00, seen);
        chk(seen[13:6] == 8'h00, "R7 reserved read", {56'h0, seen[13:6]}, 64'h0);

        // R9: overlap of read-back with a write frame
        frame(6'h06, 8'h96, seen);
        img[6*8 +: 8] = 8'h96;
        frame(6'h16, 8'h00, seen);
        frame(6'h01, 8'h4B, seen);
        img[1*8 +: 8] = 8'h4B;
        chk(seen[13:6] == 8'h96, "R9 readback during next frame", {56'h0, seen[13:6]}, 64'h96);
        chk(reg_q == img, "R9 overlapped write applied", reg_q, img);

        // R4: software reset with nonzero data
        frame(6'h04, 8'h5A, seen);
        img = RESET_IMG;
        chk(reg_q == RESET_IMG, "R4 software reset", reg_q, RESET_IMG);

        // R1: commit timing, two cycles after strobe seen high
        shift_bits(14, {18'h0, 6'h03, 8'hE7}, seen);
        sen = 1'b1;
        waitn(2);
        chk(reg_q[3*8 +: 8] == 8'hE7, "R1 commit latency", {56'h0, reg_q[3*8 +: 8]}, 64'hE7);
        sen = 1'b0;
        waitn(2);
        img[3*8 +: 8] = 8'hE7;

        // R10: reset in mid read-back
        frame(6'h17, 8'h00, seen);
        shift_bits(2, 32'h0, seen);
        chk(seen[1] == 1'b1, "R5 first bit of reg7", {63'h0, seen[1]}, 64'h1);
        rst = 1'b1;
        waitn(2);
        rst = 1'b0;
        waitn(1);
        chk(sdo == 1'b0, "R10 sdo cleared by reset", {63'h0, sdo}, 64'h0);
        chk(reg_q == RESET_IMG, "R10 registers reloaded", reg_q, RESET_IMG);
        shift_bits(6, 32'h0, seen);
        chk(seen[5:0] == 6'h0, "R10 read-back discarded", {58'h0, seen[5:0]}, 64'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule